// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This block lets a local host perform 32-bit register reads and writes on a device that is only reachable through a 16-bit management bus with a 5-bit PHY address and a 5-bit register number. It turns each host request into a short sequence of bus commands. The flat byte address is split into a page number, a bus PHY address and a bus register number. The low half-word is at the requested address and the high half-word is at that address plus 2. Each half is split on its own, so the two halves of one word can sit on different pages.

The sequencer remembers the last page value it programmed. Before a half-word access whose page differs from the remembered one, it writes the page to a fixed page-select location. Reads always fetch the low half first. For writes, a per-request order bit chooses which half goes out first. The bus side is an abstract command handshake: a strobe held with its fields until `mb_done`. Serial bit timing is handled elsewhere.

Top module: `prs_sequencer`

## Requirements
- R1: For each half-word at byte address A (A for the low half, A+2 for the high half, modulo 2^ADDR_W), the data command uses PHY address 0x10 ORed with A[8:6] and register number A[5:1].
- R2: The page of a half is A shifted right by 9, kept to 16 bits. When that page differs from the cached page, a write of the page value to PHY 0x18, register 0 is issued just before that half's data command, and the cache then holds the new page.
- R3: When the page of a half equals the cached page, no page write is issued for that half.
- R4: After reset the page cache is invalid, so the first half-word access issues a page write whatever its page (page 0 included).
- R5: A read issues the low-half read command before the high-half one. host_rdata returns {high half, low half}.
- R6: A write with host_lo_first=1 sends the low half (host_wdata[15:0]) first. With host_lo_first=0 it sends the high half (host_wdata[31:16]) first. host_rdata reads 0 after a write.
- R7: host_ack is high for exactly one cycle, in the cycle after the one where mb_done completes the final command. A strobe holds its fields steady until mb_done, and drops for at least one cycle after it.
- R8: The request fields are captured when an idle sequencer sees host_req. Changes to them while the sequence runs have no effect.
- R9: host_err at acknowledge is the OR of mb_err over every command of that request, sampled with mb_done.
- R10: During and right after reset, host_ack, both strobes, host_err and host_rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request; sampled only while idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_lo_first | input | 1 | Write order: 1 = low half first |
| host_addr | input | ADDR_W | Byte address of the 32-bit register |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with host_ack |
| host_err | output | 1 | Accumulated bus error, valid with host_ack |
| mb_phy | output | 5 | Bus PHY address of the current command |
| mb_reg | output | 5 | Bus register number of the current command |
| mb_wdata | output | 16 | Bus write data |
| mb_rd_stb | output | 1 | Read command held until done |
| mb_wr_stb | output | 1 | Write command held until done |
| mb_done | input | 1 | Current command completes this cycle |
| mb_rdata | input | 16 | Bus read data, valid with mb_done |
| mb_err | input | 1 | Bus error, valid with mb_done |

## Verification
The two functions that can land in one request are the page-cache refill and the half-word access of the other half. When a word straddles a 512-byte boundary, the refill needed for the second half follows right after the first half's data command. Addresses whose low half ends a page are used to provoke this (0x1FE, 0x5FE, and the top address, where the high half wraps to page 0), under both write orders. They are judged against a transaction log that the bench builds with its own page-cache model, entry by entry. The ack cycle is also checked against the last completion, and an error is injected on a late command.

// File: rtl/prs_pkg.sv
// Shared constants and types of the paged register sequencer.
// Assumes a 16-bit management data path and 5-bit bus address fields.
package prs_pkg;
    localparam int HALF_W = 16;
    localparam int DATA_W = 2 * HALF_W;
    localparam int MB_AW  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PAGE,
        ST_DATA,
        ST_ACK
    } prs_state_e;
endpackage

// File: rtl/prs_addr_split.sv
// Splits one half-word byte address into page, bus PHY address and bus
// register number. Purely combinational; assumes PAGE_W <= ADDR_W.
module prs_addr_split #(
    parameter int          ADDR_W   = 25,
    parameter int          PAGE_W   = 16,
    parameter logic [4:0]  PHY_BASE = 5'h10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PAGE_W-1:0] page,
    output logic [4:0]        phy,
    output logic [4:0]        regn
);
    // field extraction
    always_comb begin
        page = PAGE_W'(addr >> 9);
        phy  = PHY_BASE | {2'b00, addr[8:6]};
        regn = addr[5:1];
    end
endmodule

// File: rtl/prs_page_cache.sv
// Remembers the last page value written to the page-select location.
// Invalid after reset; a probe hits only on a valid, equal entry.
module prs_page_cache #(
    parameter int PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_page,
    input  logic [PAGE_W-1:0] probe_page,
    output logic              hit
);
    logic              valid_q;
    logic [PAGE_W-1:0] page_q;

    // cache entry update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            page_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            page_q  <= load_page;
        end
    end

    // hit compare
    always_comb hit = valid_q && (page_q == probe_page);

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid_q && page_q == $past(load_page)));
    // R4
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(load));
endmodule

// File: rtl/prs_seq_fsm.sv
// Request capture and command sequencer. Issues, per half-word, an optional
// page write and then the data command, with a low strobe cycle between
// commands. Assumes the bus keeps mb_done low while no strobe is high.
module prs_seq_fsm
    import prs_pkg::*;
#(
    parameter int          ADDR_W   = 25,
    parameter int          PAGE_W   = 16,
    parameter logic [4:0]  PAGE_PHY = 5'h18,
    parameter logic [4:0]  PAGE_REG = 5'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic              host_lo_first,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_err,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cur_hi,
    input  logic [PAGE_W-1:0] cur_page,
    input  logic [MB_AW-1:0]  cur_phy,
    input  logic [MB_AW-1:0]  cur_reg,
    input  logic              cache_hit,
    output logic              cache_load,
    output logic [MB_AW-1:0]  mb_phy,
    output logic [MB_AW-1:0]  mb_reg,
    output logic [HALF_W-1:0] mb_wdata,
    output logic              mb_rd_stb,
    output logic              mb_wr_stb,
    input  logic              mb_done,
    input  logic [HALF_W-1:0] mb_rdata,
    input  logic              mb_err
);
    prs_state_e        st;
    logic              cap_wr;
    logic              cap_lo_first;
    logic [DATA_W-1:0] cap_wdata;
    logic              phase;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic [HALF_W-1:0] cur_wdata;

    // current half: reads and low-first writes start low
    always_comb begin
        cur_hi    = phase ^ (cap_wr & ~cap_lo_first);
        cur_wdata = cur_hi ? cap_wdata[DATA_W-1:HALF_W] : cap_wdata[HALF_W-1:0];
    end

    // sequencer state, capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            cap_addr     <= '0;
            cap_wr       <= 1'b0;
            cap_lo_first <= 1'b0;
            cap_wdata    <= '0;
            phase        <= 1'b0;
            rdata_q      <= '0;
            err_q        <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (host_req) begin
                    cap_addr     <= host_addr;
                    cap_wr       <= host_wr;
                    cap_lo_first <= host_lo_first;
                    cap_wdata    <= host_wdata;
                    phase        <= 1'b0;
                    rdata_q      <= '0;
                    err_q        <= 1'b0;
                    st           <= ST_CHECK;
                end
                ST_CHECK: st <= cache_hit ? ST_DATA : ST_PAGE;
                ST_PAGE: if (mb_done) begin
                    err_q <= err_q | mb_err;
                    st    <= ST_CHECK;
                end
                ST_DATA: if (mb_done) begin
                    err_q <= err_q | mb_err;
                    if (!cap_wr) begin
                        if (cur_hi) rdata_q[DATA_W-1:HALF_W] <= mb_rdata;
                        else        rdata_q[HALF_W-1:0]      <= mb_rdata;
                    end
                    if (phase) begin
                        st <= ST_ACK;
                    end else begin
                        phase <= 1'b1;
                        st    <= ST_CHECK;
                    end
                end
                ST_ACK:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // bus command and host result outputs
    always_comb begin
        cache_load = (st == ST_PAGE) && mb_done;
        mb_wr_stb  = (st == ST_PAGE) || ((st == ST_DATA) && cap_wr);
        mb_rd_stb  = (st == ST_DATA) && !cap_wr;
        mb_phy     = (st == ST_PAGE) ? PAGE_PHY : cur_phy;
        mb_reg     = (st == ST_PAGE) ? PAGE_REG : cur_reg;
        mb_wdata   = (st == ST_PAGE) ? HALF_W'(cur_page) : cur_wdata;
        host_ack   = (st == ST_ACK);
        host_rdata = rdata_q;
        host_err   = err_q;
    end

    // R7
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mb_rd_stb || mb_wr_stb) && !mb_done) |=>
            ((mb_rd_stb || mb_wr_stb) && $stable(mb_phy) && $stable(mb_reg) && $stable(mb_wdata)));
    // R7
    cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mb_rd_stb || mb_wr_stb) && mb_done) |=> !(mb_rd_stb || mb_wr_stb));
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> ($stable(cap_addr) && $stable(cap_wdata) && $stable(cap_wr)));
    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mb_rd_stb || mb_wr_stb) && mb_done && mb_err) |=> host_err);
    // R9
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_err && st != ST_IDLE) |=> host_err);
endmodule

// File: rtl/prs_sequencer.sv
// Top of the paged indirect register access sequencer. Splits the captured
// address for both halves, selects the active half, and ties the page cache
// to the command sequencer. Assumes PAGE_W <= 16 and PAGE_W <= ADDR_W.
module prs_sequencer
    import prs_pkg::*;
#(
    parameter int          ADDR_W   = 25,
    parameter int          PAGE_W   = 16,
    parameter logic [4:0]  PHY_BASE = 5'h10,
    parameter logic [4:0]  PAGE_PHY = 5'h18,
    parameter logic [4:0]  PAGE_REG = 5'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic              host_lo_first,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic              host_ack,
    output logic [31:0]       host_rdata,
    output logic              host_err,
    output logic [4:0]        mb_phy,
    output logic [4:0]        mb_reg,
    output logic [15:0]       mb_wdata,
    output logic              mb_rd_stb,
    output logic              mb_wr_stb,
    input  logic              mb_done,
    input  logic [15:0]       mb_rdata,
    input  logic              mb_err
);
    localparam int HALVES = 2;

    logic [ADDR_W-1:0] cap_addr;
    logic              cur_hi;
    logic [PAGE_W-1:0] hp_page [HALVES];
    logic [MB_AW-1:0]  hp_phy  [HALVES];
    logic [MB_AW-1:0]  hp_reg  [HALVES];
    logic [PAGE_W-1:0] cur_page;
    logic [MB_AW-1:0]  cur_phy;
    logic [MB_AW-1:0]  cur_reg;
    logic              cache_hit;
    logic              cache_load;

    // one splitter per half-word; half h sits at byte offset 2*h
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [ADDR_W-1:0] half_addr;
        assign half_addr = cap_addr + ADDR_W'(2 * h);
        prs_addr_split #(
            .ADDR_W  (ADDR_W),
            .PAGE_W  (PAGE_W),
            .PHY_BASE(PHY_BASE)
        ) u_split (
            .addr(half_addr),
            .page(hp_page[h]),
            .phy (hp_phy[h]),
            .regn(hp_reg[h])
        );
    end

    // active half select
    always_comb begin
        cur_page = cur_hi ? hp_page[1] : hp_page[0];
        cur_phy  = cur_hi ? hp_phy[1]  : hp_phy[0];
        cur_reg  = cur_hi ? hp_reg[1]  : hp_reg[0];
    end

    prs_page_cache #(.PAGE_W(PAGE_W)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cache_load),
        .load_page (cur_page),
        .probe_page(cur_page),
        .hit       (cache_hit)
    );

    prs_seq_fsm #(
        .ADDR_W  (ADDR_W),
        .PAGE_W  (PAGE_W),
        .PAGE_PHY(PAGE_PHY),
        .PAGE_REG(PAGE_REG)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req     (host_req),
        .host_wr      (host_wr),
        .host_lo_first(host_lo_first),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_ack     (host_ack),
        .host_rdata   (host_rdata),
        .host_err     (host_err),
        .cap_addr     (cap_addr),
        .cur_hi       (cur_hi),
        .cur_page     (cur_page),
        .cur_phy      (cur_phy),
        .cur_reg      (cur_reg),
        .cache_hit    (cache_hit),
        .cache_load   (cache_load),
        .mb_phy       (mb_phy),
        .mb_reg       (mb_reg),
        .mb_wdata     (mb_wdata),
        .mb_rd_stb    (mb_rd_stb),
        .mb_wr_stb    (mb_wr_stb),
        .mb_done      (mb_done),
        .mb_rdata     (mb_rdata),
        .mb_err       (mb_err)
    );

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mb_rd_stb && mb_wr_stb));
endmodule

// File: tb/prs_sequencer_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a responder logs every bus command, and a bench-side
// page-cache model predicts the command list and results of each request.
module prs_sequencer_tb_top;
    localparam int AW = 25;

    typedef struct packed {
        logic          wr;
        logic          lf;
        logic [3:0]    lat;
        logic [AW-1:0] addr;
        logic [31:0]   wdata;
        logic [3:0]    erri;   // command index that reports an error, 15 = none
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 4'd0, 25'h0000000, 32'h00000000, 4'hF},  // first access, page 0
        '{1'b0, 1'b1, 4'd1, 25'h0000004, 32'h00000000, 4'hF},  // same page, no page write
        '{1'b1, 1'b1, 4'd2, 25'h00000C0, 32'hA5A55A5A, 4'hF},  // low half first
        '{1'b1, 1'b0, 4'd0, 25'h00003A4, 32'h12345678, 4'hF},  // new page, high half first
        '{1'b0, 1'b1, 4'd1, 25'h00001FE, 32'h00000000, 4'hF},  // read straddling pages
        '{1'b1, 1'b0, 4'd0, 25'h00005FE, 32'hDEADBEEF, 4'hF},  // write straddling, high first
        '{1'b0, 1'b0, 4'd2, 25'h01ABCDE, 32'h00000000, 4'd1},  // error on low data read
        '{1'b1, 1'b1, 4'd3, 25'h1FFFFFE, 32'hCAFEF00D, 4'd3}   // top address, wrap, late error
    };
    localparam string VTAG [NV] = '{"R4", "R3", "R6", "R6", "R5", "R6", "R9", "R9"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_lo_first = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        host_err;
    logic [4:0]  mb_phy;
    logic [4:0]  mb_reg;
    logic [15:0] mb_wdata;
    logic        mb_rd_stb;
    logic        mb_wr_stb;
    logic        mb_done = 1'b0;
    logic [15:0] mb_rdata = '0;
    logic        mb_err = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    prs_sequencer dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_wr(host_wr), .host_lo_first(host_lo_first),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .host_err(host_err),
        .mb_phy(mb_phy), .mb_reg(mb_reg), .mb_wdata(mb_wdata),
        .mb_rd_stb(mb_rd_stb), .mb_wr_stb(mb_wr_stb),
        .mb_done(mb_done), .mb_rdata(mb_rdata), .mb_err(mb_err)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // responder state and command log
    int          lat_r = 0;
    int          err_ix = 15;
    int          rcnt = 0;
    int          log_n = 0;
    int          last_done = 0;
    logic [31:0] lg [8];

    // bus model read data, a fixed function of the command address
    function automatic logic [15:0] rfun(input logic [4:0] p, input logic [4:0] r);
        return 16'(p * 16'd977 + r * 16'd131 + 16'h1357);
    endfunction

    // responder: completes a held strobe after lat_r extra cycles, logs it
    always @(negedge clk) begin
        if (!rst_n) begin
            mb_done = 1'b0; mb_err = 1'b0; rcnt = 0;
        end else if ((mb_rd_stb || mb_wr_stb) && !mb_done) begin
            if (rcnt >= lat_r) begin
                mb_done  = 1'b1;
                mb_err   = (log_n == err_ix);
                mb_rdata = rfun(mb_phy, mb_reg);
                if (log_n < 8) lg[log_n] = {5'd0, mb_wr_stb, mb_phy, mb_reg, mb_wdata};
                log_n     = log_n + 1;
                last_done = cyc;
                rcnt      = 0;
            end else begin
                rcnt = rcnt + 1;
            end
        end else begin
            mb_done = 1'b0; mb_err = 1'b0; rcnt = 0;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    // bench page-cache model
    bit          mdl_valid = 1'b0;
    logic [15:0] mdl_page = '0;

    task automatic do_reset();
        rst_n = 1'b0;
        mdl_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R10: outputs while in reset
        chk(!host_ack && !mb_rd_stb && !mb_wr_stb && !host_err && host_rdata == 0,
            "R10", "reset outputs", {host_ack, mb_rd_stb, mb_wr_stb, host_err, host_rdata[27:0]}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!host_ack && !mb_rd_stb && !mb_wr_stb && !host_err && host_rdata == 0,
            "R10", "after reset", {host_ack, mb_rd_stb, mb_wr_stb, host_err, host_rdata[27:0]}, 0);
    endtask

    task automatic do_req(input vec_t v, input bit scramble, input string tag);
        logic [31:0] exp_e [8];
        int          exp_n = 0;
        logic [31:0] exp_rd = '0;
        bit          hi_first = v.wr && !v.lf;
        bit          got = 1'b0;
        int          waited = 0;
        int          ack_cyc;
        logic [31:0] rd;
        logic        er;
        // build the expected command list from the requirements
        for (int i = 0; i < 2; i++) begin
            logic          h;
            logic [AW-1:0] a;
            logic [15:0]   pg;
            logic [4:0]    p;
            logic [4:0]    r;
            logic [15:0]   d;
            h  = 1'(i) ^ hi_first;
            a  = v.addr + (h ? 25'd2 : 25'd0);
            pg = 16'(a >> 9);
            if (!mdl_valid || pg != mdl_page) begin
                exp_e[exp_n] = {5'd0, 1'b1, 5'h18, 5'h00, pg};
                exp_n++;
                mdl_valid = 1'b1;
                mdl_page  = pg;
            end
            p = 5'h10 | {2'b00, a[8:6]};
            r = a[5:1];
            d = h ? v.wdata[31:16] : v.wdata[15:0];
            exp_e[exp_n] = {5'd0, v.wr, p, r, d};
            exp_n++;
            if (!v.wr) begin
                if (h) exp_rd[31:16] = rfun(p, r);
                else   exp_rd[15:0]  = rfun(p, r);
            end
        end
        lat_r = int'(v.lat);
        err_ix = int'(v.erri);
        log_n = 0;
        @(negedge clk);
        host_req = 1'b1; host_wr = v.wr; host_lo_first = v.lf;
        host_addr = v.addr; host_wdata = v.wdata;
        while (!got && waited < 400) begin
            @(negedge clk);
            waited++;
            if (scramble && waited == 3) begin
                host_addr = ~v.addr; host_wdata = ~v.wdata;
                host_wr = ~v.wr; host_lo_first = ~v.lf;
            end
            if (host_ack) got = 1'b1;
        end
        ack_cyc = cyc;
        rd = host_rdata;
        er = host_err;
        host_req = 1'b0;
        chk(got, "R7", "ack seen", 32'(got), 1);
        chk(ack_cyc == last_done + 1, "R7", "ack one cycle after last done", ack_cyc - last_done, 1);
        @(negedge clk);
        chk(!host_ack, "R7", "ack single cycle", 32'(host_ack), 0);
        chk(log_n == exp_n, tag, "command count", log_n, exp_n);
        for (int k = 0; k < exp_n && k < log_n && k < 8; k++) begin
            logic [31:0] ev;
            logic [31:0] lv;
            ev = exp_e[k];
            lv = lg[k];
            if (!ev[26]) begin  // reads: data field is not meaningful
                ev[15:0] = '0;
                lv[15:0] = '0;
            end
            chk(lv == ev, (ev[25:21] == 5'h18) ? "R2" : "R1", "command entry", lv, ev);
        end
        chk(rd == exp_rd, v.wr ? "R6" : "R5", "returned data", rd, exp_rd);
        chk(er == (int'(v.erri) < exp_n), "R9", "error flag", 32'(er), 32'(int'(v.erri) < exp_n));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) do_req(VEC[i], 1'b0, VTAG[i]);
        // R8: request fields change while the sequence runs
        do_req('{1'b0, 1'b0, 4'd2, 25'h0000010, 32'h0, 4'hF}, 1'b1, "R8");
        // R4: a fresh reset forgets the cached page 0, so page 0 is rewritten
        do_reset();
        do_req('{1'b0, 1'b1, 4'd0, 25'h0000000, 32'h0, 4'hF}, 1'b0, "R4");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule